// File: doc/BRIEF.md
# Triple-DES Key Register Bank

This block holds the keys for a DES / triple-DES cipher engine. A host loads up to three 64-bit keys through a small memory-mapped bus. The keys cannot be read back: any read of a key address returns zero and raises an address-error interrupt. A key-size input selects the cipher mode. The block drives the three keys the engine uses and a flag that says the keys needed for the selected mode are all present.

A write to the first key slot also writes the same value into the third slot in the same clock edge. Two-key triple DES (K1, K2, K1) therefore becomes ready once K1 and K2 are written. Three-key triple DES needs a strict write order: K1, then K2, then K3. A write-order state machine tracks which keys have been accepted. Its states are `ST_EMPTY` (nothing loaded), `ST_K1` (K1 loaded and mirrored into K3), `ST_K2` (K2 loaded after K1) and `ST_K3` (K3 loaded after K2). It has four named transitions:
- `T_LOAD1`: an accepted K1 write, from any state to `ST_K1`.
- `T_LOAD2`: an accepted K2 write, from `ST_K1`, `ST_K2` or `ST_K3` to `ST_K2`.
- `T_LOAD3`: an accepted K3 write, from `ST_K2` or `ST_K3` to `ST_K3`.
- `T_CLEAR`: a synchronous clear, from any state to `ST_EMPTY`.

A write that is not accepted leaves the state, and the keys, unchanged.

Top module: `tdes_key_bank`

## Requirements
- R1: Reset, and a synchronous clear on `clear_i`, zero all three keys, drop `keys_valid` and return write tracking to empty. A clear wins over a bus access in the same cycle: that access has no effect and raises no error.
- R2: An accepted write to the K1 address (byte address 0x00) loads the data into both `key1` and `key3` at the same clock edge. The new value is visible in the cycle after the write.
- R3: The `key_size` input is read in bytes: 8 selects single DES, 16 two-key triple DES and 24 three-key triple DES. With any other value, every key write is ignored, pulses `bus_err`, and `keys_valid` is 0.
- R4: In single-DES mode, a write to the K2 address (0x08) or the K3 address (0x10) is ignored and pulses `bus_err`.
- R5: In two-key mode, `keys_valid` is 1 once K1 and then K2 have been accepted, with `key3` equal to `key1`. A K2 write before any K1 write, or any K3 write, is ignored and pulses `bus_err`.
- R6: In three-key mode, K2 is accepted only after K1, and K3 only after K2. A write out of this order is ignored and pulses `bus_err`.
- R7: `keys_valid` is 1 in single mode after K1, in two-key mode after K2 (once K1 is in), and in three-key mode only in the `ST_K3` state.
- R8: A read of any key address returns 0 on `bus_rdata`, pulses `addr_err_irq` and `bus_err`, and leaves the keys unchanged.
- R9: `bus_err` and `addr_err_irq` are registered. They are high for exactly the one cycle after the offending access.
- R10: Rewriting K1 in three-key mode after `ST_K3` drops `keys_valid`, mirrors the new K1 into `key3`, and needs K2 and K3 to be written again.
- R11: Reads and writes to non-key addresses (for example 0x18) change no key, raise no error and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of keys and tracking |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, always zero |
| bus_err | output | 1 | One-cycle error pulse after a rejected access |
| key_size | input | 5 | Key size in bytes: 8, 16 or 24 |
| key1 | output | 64 | Effective first key |
| key2 | output | 64 | Effective second key |
| key3 | output | 64 | Effective third key |
| keys_valid | output | 1 | Keys required by the selected mode are loaded |
| addr_err_irq | output | 1 | One-cycle interrupt after a key read |

## Verification
The write sequence is driven in each mode in legal order, with K2 before K1, and with K3 before K2. This separates order tracking from plain storage, and shows whether the mode gates which slots are writable. Rewriting K1 after a full three-key load tells mirroring apart from an independent K3 store, and shows whether validity falls back. Key reads, non-key accesses, an illegal key size, and a clear in the same cycle as a write show that traps and rejects never disturb stored keys. A behavioural model in the bench is compared with every output on every clock.

// File: rtl/tdes_kb_pkg.sv
package tdes_kb_pkg;

    localparam int NUM_KEYS = 3;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_K1    = 2'd1,
        ST_K2    = 2'd2,
        ST_K3    = 2'd3
    } kb_state_e;

    typedef enum logic [1:0] {
        MODE_BAD    = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_TWO    = 2'd2,
        MODE_THREE  = 2'd3
    } kb_mode_e;

endpackage

// File: rtl/kb_addr_decode.sv
module kb_addr_decode
    import tdes_kb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int KEY_BASE   = 0,
    parameter int KEY_STRIDE = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                rd,
    output logic [NUM_KEYS-1:0] wr_sel,
    output logic                rd_hit
);

    logic [NUM_KEYS-1:0] hit;

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_slot_match
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(KEY_BASE + i * KEY_STRIDE);
        assign hit[i] = (addr == SLOT_ADDR);
    end

    assign wr_sel = hit & {NUM_KEYS{wr}};
    assign rd_hit = rd & (|hit);

endmodule

// File: rtl/kb_order_fsm.sv
module kb_order_fsm
    import tdes_kb_pkg::*;
#(
    parameter int SIZE_W     = 5,
    parameter int SIZE_ONE   = 8,
    parameter int SIZE_TWO   = 16,
    parameter int SIZE_THREE = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [SIZE_W-1:0]   key_size,
    input  logic [NUM_KEYS-1:0] wr_sel,
    output logic [NUM_KEYS-1:0] load,
    output logic                wr_err,
    output logic                keys_valid
);

    localparam logic [SIZE_W-1:0] SZ1 = SIZE_W'(SIZE_ONE);
    localparam logic [SIZE_W-1:0] SZ2 = SIZE_W'(SIZE_TWO);
    localparam logic [SIZE_W-1:0] SZ3 = SIZE_W'(SIZE_THREE);

    kb_state_e state_q, state_d;
    kb_mode_e  mode;
    logic      acc1, acc2, acc3;

    // mode from the byte count
    always_comb begin
        if (key_size == SZ1)      mode = MODE_SINGLE;
        else if (key_size == SZ2) mode = MODE_TWO;
        else if (key_size == SZ3) mode = MODE_THREE;
        else                      mode = MODE_BAD;
    end

    // which writes are legal in the current state and mode
    always_comb begin
        acc1 = !clear && wr_sel[0] && (mode != MODE_BAD);
        acc2 = !clear && wr_sel[1] && (mode == MODE_TWO || mode == MODE_THREE)
               && (state_q != ST_EMPTY);
        acc3 = !clear && wr_sel[2] && (mode == MODE_THREE)
               && (state_q == ST_K2 || state_q == ST_K3);
    end

    // next state: T_CLEAR, T_LOAD1, T_LOAD2, T_LOAD3
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: if (acc1) state_d = ST_K1;
                ST_K1: begin
                    if (acc1)      state_d = ST_K1;
                    else if (acc2) state_d = ST_K2;
                end
                ST_K2, ST_K3: begin
                    if (acc1)      state_d = ST_K1;
                    else if (acc2) state_d = ST_K2;
                    else if (acc3) state_d = ST_K3;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load   = {acc3, acc2, acc1};
        wr_err = !clear && (|wr_sel) && !(acc1 || acc2 || acc3);
        unique case (state_q)
            ST_EMPTY: keys_valid = 1'b0;
            ST_K1:    keys_valid = (mode == MODE_SINGLE);
            ST_K2:    keys_valid = (mode == MODE_SINGLE) || (mode == MODE_TWO);
            ST_K3:    keys_valid = (mode != MODE_BAD);
            default:  keys_valid = 1'b0;
        endcase
    end

    // R1: clear always brings tracking back to empty
    p_clear_to_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == ST_EMPTY && !keys_valid));

    // R4: single mode never takes a K2 write
    p_single_blocks_k2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && mode == MODE_SINGLE && wr_sel[1]) |-> (!load[1] && wr_err));

    // R6: an accepted K3 write lands in the full three-key state
    p_k3_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load[2] |=> (state_q == ST_K3));

    // R10: a K1 write restarts the order
    p_k1_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load[0] |=> (state_q == ST_K1));

endmodule

// File: rtl/kb_key_slots.sv
module kb_key_slots
    import tdes_kb_pkg::*;
#(
    parameter int KEY_W = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic [NUM_KEYS-1:0]            load,
    input  logic [KEY_W-1:0]               wdata,
    output logic [NUM_KEYS-1:0][KEY_W-1:0] key_q
);

    localparam int MIRROR_IDX = NUM_KEYS - 1;

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_slot
        logic take;
        if (i == MIRROR_IDX) begin : g_mirror
            assign take = load[i] || load[0];
        end else begin : g_plain
            assign take = load[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     key_q[i] <= '0;
            else if (clear) key_q[i] <= '0;
            else if (take)  key_q[i] <= wdata;
        end
    end

    // R2: the third slot follows every first-slot load
    p_mirror_k1_k3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load[0] |=> (key_q[MIRROR_IDX] == key_q[0] && key_q[0] == $past(wdata)));

    // R1: clear empties every slot
    p_clear_zeroes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (key_q == '0));

endmodule

// File: rtl/tdes_key_bank.sv
module tdes_key_bank
    import tdes_kb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int KEY_W      = 64,
    parameter int SIZE_W     = 5,
    parameter int KEY_BASE   = 0,
    parameter int KEY_STRIDE = 8,
    parameter int SIZE_ONE   = 8,
    parameter int SIZE_TWO   = 16,
    parameter int SIZE_THREE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [KEY_W-1:0]  bus_wdata,
    output logic [KEY_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [SIZE_W-1:0] key_size,
    output logic [KEY_W-1:0]  key1,
    output logic [KEY_W-1:0]  key2,
    output logic [KEY_W-1:0]  key3,
    output logic              keys_valid,
    output logic              addr_err_irq
);

    logic [NUM_KEYS-1:0]            wr_sel;
    logic [NUM_KEYS-1:0]            load;
    logic                           rd_hit;
    logic                           wr_err;
    logic                           rd_trap;
    logic [NUM_KEYS-1:0][KEY_W-1:0] key_q;

    kb_addr_decode #(
        .ADDR_W    (ADDR_W),
        .KEY_BASE  (KEY_BASE),
        .KEY_STRIDE(KEY_STRIDE)
    ) u_decode (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wr_sel(wr_sel),
        .rd_hit(rd_hit)
    );

    kb_order_fsm #(
        .SIZE_W    (SIZE_W),
        .SIZE_ONE  (SIZE_ONE),
        .SIZE_TWO  (SIZE_TWO),
        .SIZE_THREE(SIZE_THREE)
    ) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_i),
        .key_size  (key_size),
        .wr_sel    (wr_sel),
        .load      (load),
        .wr_err    (wr_err),
        .keys_valid(keys_valid)
    );

    kb_key_slots #(
        .KEY_W(KEY_W)
    ) u_slots (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear_i),
        .load (load),
        .wdata(bus_wdata),
        .key_q(key_q)
    );

    assign rd_trap = rd_hit && !clear_i;

    // registered error pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_err      <= 1'b0;
            addr_err_irq <= 1'b0;
        end else begin
            bus_err      <= wr_err || rd_trap;
            addr_err_irq <= rd_trap;
        end
    end

    assign bus_rdata = '0;
    assign key1      = key_q[0];
    assign key2      = key_q[1];
    assign key3      = key_q[2];

    // R8: a key read traps on the next cycle
    p_read_traps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rd_hit && !clear_i) |=> (addr_err_irq && bus_err));

    // R8: a pure read never moves a key
    p_read_keeps_keys_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && !clear_i) |=> ($stable(key1) && $stable(key2) && $stable(key3)));

    // R9: the interrupt never stands without the error pulse
    p_irq_with_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_irq |-> bus_err);

endmodule

// File: tb/test_tdes_key_bank.sv
module test_tdes_key_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_err;
    logic [4:0]  key_size = 5'd8;
    logic [63:0] key1, key2, key3;
    logic        keys_valid;
    logic        addr_err_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tdes_key_bank i_tdes_key_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_err     (bus_err),
        .key_size    (key_size),
        .key1        (key1),
        .key2        (key2),
        .key3        (key3),
        .keys_valid  (keys_valid),
        .addr_err_irq(addr_err_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference: keys, count of ordered loads, pending pulses
    logic [63:0] m_k[3];
    int          m_have = 0;
    logic        m_err = 0, m_irq = 0;

    initial begin
        for (int i = 0; i < 3; i++) m_k[i] = '0;
    end

    function automatic int size_mode(input logic [4:0] s);
        if (s == 5'd8)  return 1;
        if (s == 5'd16) return 2;
        if (s == 5'd24) return 3;
        return 0;
    endfunction

    function automatic bit m_valid();
        int md = size_mode(key_size);
        if (md == 1) return m_have >= 1;
        if (md == 2) return m_have >= 2;
        if (md == 3) return m_have == 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit e, q;
        int md;
        e = 0; q = 0;
        md = size_mode(key_size);
        if (!rst_n || clear_i) begin
            for (int i = 0; i < 3; i++) m_k[i] = '0;
            m_have = 0;
        end else begin
            if (bus_wr) begin
                if (bus_addr == 8'h00) begin
                    if (md == 0) e = 1;
                    else begin m_k[0] = bus_wdata; m_k[2] = bus_wdata; m_have = 1; end
                end else if (bus_addr == 8'h08) begin
                    if (md < 2 || m_have == 0) e = 1;
                    else begin m_k[1] = bus_wdata; m_have = 2; end
                end else if (bus_addr == 8'h10) begin
                    if (md != 3 || m_have < 2) e = 1;
                    else begin m_k[2] = bus_wdata; m_have = 3; end
                end
            end
            if (bus_rd && (bus_addr == 8'h00 || bus_addr == 8'h08 || bus_addr == 8'h10)) begin
                q = 1; e = 1;
            end
        end
        m_err = e;
        m_irq = q;
    end

    // compare every output on every clock, away from the edge
    always @(posedge clk) begin
        #2;
        chk("R2 key1 model", key1, m_k[0]);
        chk("R5 key2 model", key2, m_k[1]);
        chk("R6 key3 model", key3, m_k[2]);
        chk("R7 keys_valid model", 64'(keys_valid), 64'(m_valid()));
        chk("R9 bus_err model", 64'(bus_err), 64'(m_err));
        chk("R8 addr_err_irq model", 64'(addr_err_irq), 64'(m_irq));
        chk("R11 bus_rdata model", bus_rdata, 64'h0);
    end

    task automatic wr_op(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_op(input logic [7:0] a, output logic [63:0] rdv);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1 rdv = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset key1", key1, 64'h0);
        chk("R1 reset valid", 64'(keys_valid), 64'h0);

        // single DES
        key_size = 5'd8;
        wr_op(8'h08, 64'hDEAD_0000_0000_0002);
        chk("R4 K2 rejected err", 64'(bus_err), 64'h1);
        chk("R4 K2 ignored", key2, 64'h0);
        wr_op(8'h00, 64'h1111_2222_3333_4444);
        chk("R2 K1 stored", key1, 64'h1111_2222_3333_4444);
        chk("R2 K1 mirrored to K3", key3, 64'h1111_2222_3333_4444);
        chk("R7 single valid", 64'(keys_valid), 64'h1);
        wr_op(8'h10, 64'hDEAD_0000_0000_0003);
        chk("R4 K3 rejected err", 64'(bus_err), 64'h1);
        chk("R4 K3 ignored", key3, 64'h1111_2222_3333_4444);

        // key read trap
        rd_op(8'h00, rv);
        chk("R8 rdata zero", rv, 64'h0);
        chk("R8 irq pulse", 64'(addr_err_irq), 64'h1);
        chk("R8 keys kept", key1, 64'h1111_2222_3333_4444);
        @(negedge clk);
        chk("R9 irq one cycle", 64'(addr_err_irq), 64'h0);
        chk("R9 err one cycle", 64'(bus_err), 64'h0);

        // two-key
        do_clear();
        chk("R1 clear key3", key3, 64'h0);
        key_size = 5'd16;
        wr_op(8'h08, 64'hBAD0_0000_0000_0002);
        chk("R5 K2 before K1 err", 64'(bus_err), 64'h1);
        wr_op(8'h00, 64'hAAAA_0000_0000_0001);
        chk("R5 not yet valid", 64'(keys_valid), 64'h0);
        wr_op(8'h08, 64'hBBBB_0000_0000_0002);
        chk("R5 two-key valid", 64'(keys_valid), 64'h1);
        chk("R5 K3 equals K1", key3, 64'hAAAA_0000_0000_0001);
        wr_op(8'h10, 64'hBAD0_0000_0000_0003);
        chk("R5 K3 write rejected", key3, 64'hAAAA_0000_0000_0001);

        // three-key
        do_clear();
        key_size = 5'd24;
        wr_op(8'h00, 64'hC1C1_C1C1_C1C1_C1C1);
        wr_op(8'h10, 64'hBAD0_0000_0000_0033);
        chk("R6 K3 before K2 err", 64'(bus_err), 64'h1);
        chk("R6 K3 kept mirror", key3, 64'hC1C1_C1C1_C1C1_C1C1);
        wr_op(8'h08, 64'hC2C2_C2C2_C2C2_C2C2);
        chk("R7 three-key not valid at K2", 64'(keys_valid), 64'h0);
        wr_op(8'h10, 64'hC3C3_C3C3_C3C3_C3C3);
        chk("R6 K3 stored", key3, 64'hC3C3_C3C3_C3C3_C3C3);
        chk("R7 three-key valid", 64'(keys_valid), 64'h1);
        wr_op(8'h00, 64'hD1D1_D1D1_D1D1_D1D1);
        chk("R10 valid dropped", 64'(keys_valid), 64'h0);
        chk("R10 K3 remirrored", key3, 64'hD1D1_D1D1_D1D1_D1D1);
        wr_op(8'h08, 64'hD2D2_D2D2_D2D2_D2D2);
        wr_op(8'h10, 64'hD3D3_D3D3_D3D3_D3D3);
        chk("R10 valid again", 64'(keys_valid), 64'h1);

        // non-key address
        wr_op(8'h18, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R11 no err on other addr", 64'(bus_err), 64'h0);
        rd_op(8'h18, rv);
        chk("R11 no irq on other addr", 64'(addr_err_irq), 64'h0);
        chk("R11 rdata zero", rv, 64'h0);

        // illegal key size
        key_size = 5'd12;
        @(negedge clk);
        chk("R3 bad size not valid", 64'(keys_valid), 64'h0);
        wr_op(8'h00, 64'h0BAD_0BAD_0BAD_0BAD);
        chk("R3 bad size err", 64'(bus_err), 64'h1);
        chk("R3 bad size ignored", key1, 64'hD1D1_D1D1_D1D1_D1D1);

        // clear with simultaneous write
        key_size = 5'd8;
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 64'h5555_5555_5555_5555; bus_wr = 1'b1; clear_i = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; clear_i = 1'b0;
        chk("R1 clear beats write", key1, 64'h0);
        chk("R1 clear no err", 64'(bus_err), 64'h0);
        chk("R1 clear invalid", 64'(keys_valid), 64'h0);

        // back-to-back key reads keep the pulse high
        @(negedge clk);
        bus_addr = 8'h08; bus_rd = 1'b1;
        @(negedge clk);
        bus_addr = 8'h10;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R8 second read irq", 64'(addr_err_irq), 64'h1);
        @(negedge clk);
        chk("R9 pulse ends", 64'(addr_err_irq), 64'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule